// File: doc/BRIEF.md
# Microstep Translator with Decay Select

This block turns a step/direction command stream into per-phase current commands for a two-phase bipolar stepper. It holds a 5-bit electrical position counted in eighth-step units (32 positions per electrical cycle). Each accepted rising edge on the step input moves the position forward or backward by 8, 4, 2 or 1 units, depending on the resolution inputs. From the position it derives, for each phase, a current magnitude code and a polarity bit. The codes follow a cosine curve for phase A and a sine curve for phase B.

For each phase the block also picks a decay mode from the current change that a step commands. A phase whose magnitude does not fall gets slow decay. A phase whose magnitude falls gets the mode on the 2-bit external decay select. The external select carries the result of an outside threshold comparison.

Reset, sleep and enable gate the block. Reset and sleep return it to a home position. Enable only switches the bridge-enable output. After a wake from sleep, a settle timer refuses steps for a programmable number of clock cycles. The analog DAC, the comparators and the bridges sit outside the block.

Top module: `microstep_translator`

## Requirements
- R1: Resolution code `resSel` 2'b00, 2'b01, 2'b10 and 2'b11 select step sizes of 8, 4, 2 and 1 position units (full, half, quarter and eighth step). The position wraps modulo 32.
- R2: Only a rising edge of `stepIn` moves the position. `stepIn` passes through a two-flop synchroniser, so the outputs change on the third rising clock edge after `stepIn` goes high. With `dirIn`=1 the position increases, and with 0 it decreases.
- R3: `resSel` takes effect only at an accepted step edge. Changing it with no step leaves every output unchanged.
- R4: While `rstN` is low, the position is home and `bridgeEn` is 0. Both decay outputs read mixed, and step edges are ignored. After release the position is still home.
- R5: Phase A magnitude is |cos(p*11.25 deg)| and phase B magnitude is |sin(p*11.25 deg)|. Both use the quarter-wave code table 0, 49, 97, 142, 181, 212, 236, 251, 255 (8-bit codes, index k = angle/11.25 deg within the quarter). `polA`=1 for p in 0..7 or 24..31, and `polB`=1 for p in 0..15.
- R6: Decay encoding is 2'b00 slow, 2'b01 fast, 2'b10 mixed. On a step, a phase whose new magnitude is lower than its previous one takes `decaySel`. Any other phase takes slow.
- R7: `homeOut` is 1 exactly when the position is home (p = 4: both magnitudes 181, both polarities 1).
- R8: `enN`=1 forces `bridgeEn` to 0, but steps, direction and resolution are still processed. With `enN`=0, `rstN`=1 and `sleepN`=1, `bridgeEn` is 1.
- R9: While `sleepN` is low, the position is held home, both decays read mixed, `bridgeEn` is 0 and steps are ignored.
- R10: After `sleepN` rises, step edges arriving during the first SETTLE_CYCLES clock cycles are dropped. Later steps are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset to home |
| stepIn | input | 1 | Step command, rising edge active, asynchronous |
| dirIn | input | 1 | Direction, 1 forward |
| resSel | input | 2 | Microstep resolution code |
| decaySel | input | 2 | Externally selected decay for falling current |
| enN | input | 1 | Active-low bridge enable |
| sleepN | input | 1 | Active-low sleep |
| magA | output | MAG_W | Phase A current magnitude code |
| polA | output | 1 | Phase A polarity, 1 positive |
| magB | output | MAG_W | Phase B current magnitude code |
| polB | output | 1 | Phase B polarity, 1 positive |
| decayA | output | 2 | Phase A decay mode |
| decayB | output | 2 | Phase B decay mode |
| homeOut | output | 1 | Position is home |
| bridgeEn | output | 1 | Bridge drivers may conduct |

## Verification
A corrupted position register shows up on the magnitude and polarity pairs on the very cycle the register changes. This is because the codes are pure lookups of the position. A wrong step size or wrong direction therefore appears three clock edges after the step input rises. A wrong previous-magnitude comparison shows only on the decay outputs, in the same cycle as the position update, so each step is checked against a model of the magnitude change. A settle counter that is off shows up as a missing or extra step right after a wake.

// File: rtl/mstep_pkg.sv
`timescale 1ns/1ps
package mstep_pkg;
  localparam int IDX_W    = 5;
  localparam int HOME_IDX = 4;
  localparam int QUARTER  = 8;

  typedef enum logic [1:0] {
    DECAY_SLOW  = 2'b00,
    DECAY_FAST  = 2'b01,
    DECAY_MIXED = 2'b10
  } decay_e;

  typedef struct packed {
    logic advance;
    logic forward;
    logic goHome;
  } ctlStrobe_t;

  // 16-bit full-scale sine samples at 11.25 degree spacing, first quadrant
  function automatic logic [15:0] quarterSine(input logic [3:0] k);
    case (k)
      4'd0:    return 16'd0;
      4'd1:    return 16'd12785;
      4'd2:    return 16'd25080;
      4'd3:    return 16'd36410;
      4'd4:    return 16'd46340;
      4'd5:    return 16'd54491;
      4'd6:    return 16'd60547;
      4'd7:    return 16'd64276;
      default: return 16'd65535;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] stepSize(input logic [1:0] res);
    return IDX_W'(QUARTER) >> res;
  endfunction
endpackage

// File: rtl/mstep_control.sv
`timescale 1ns/1ps
module mstep_control
  import mstep_pkg::*;
#(
  parameter int SETTLE_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepIn,
  input  logic       dirIn,
  input  logic       enN,
  input  logic       sleepN,
  output ctlStrobe_t ctl,
  output logic       bridgeEn
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

  logic [1:0]       stepSync;
  logic             stepPrev;
  logic             stepRise;
  logic [CNT_W-1:0] settleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepSync <= '0;
      stepPrev <= 1'b0;
    end else begin
      stepSync <= {stepSync[0], stepIn};
      stepPrev <= stepSync[1];
    end
  end

  assign stepRise = stepSync[1] & ~stepPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      settleCnt <= '0;
    else if (!sleepN)
      settleCnt <= CNT_W'(SETTLE_CYCLES);
    else if (settleCnt != '0)
      settleCnt <= settleCnt - 1'b1;
  end

  always_comb begin
    ctl.advance = stepRise & sleepN & (settleCnt == '0);
    ctl.forward = dirIn;
    ctl.goHome  = ~sleepN;
  end

  assign bridgeEn = rstN & sleepN & ~enN;
endmodule

// File: rtl/mstep_datapath.sv
`timescale 1ns/1ps
module mstep_datapath
  import mstep_pkg::*;
#(
  parameter int MAG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic [1:0]       resSel,
  input  logic [1:0]       decaySel,
  output logic [IDX_W-1:0] idx,
  output logic [MAG_W-1:0] mag [2],
  output logic             pol [2],
  output logic [1:0]       decay [2]
);
  logic [IDX_W-1:0] nextIdx;

  function automatic logic [MAG_W-1:0] lutMag(input logic [IDX_W-1:0] p);
    logic [3:0]  k;
    logic [15:0] raw;
    k   = p[3] ? 4'(4'd8 - {1'b0, p[2:0]}) : {1'b0, p[2:0]};
    raw = quarterSine(k);
    return raw[15 -: MAG_W];
  endfunction

  always_comb begin
    if (ctl.forward) nextIdx = idx + stepSize(resSel);
    else             nextIdx = idx - stepSize(resSel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            idx <= IDX_W'(HOME_IDX);
    else if (ctl.goHome)  idx <= IDX_W'(HOME_IDX);
    else if (ctl.advance) idx <= nextIdx;
  end

  // phase 0 = cosine (quarter-cycle lead), phase 1 = sine
  for (genvar ph = 0; ph < 2; ph++) begin : g_phase
    localparam logic [IDX_W-1:0] OFF = (ph == 0) ? IDX_W'(QUARTER) : '0;
    logic [IDX_W-1:0] curPos, newPos;
    logic [MAG_W-1:0] newMag;
    decay_e           decayQ;

    assign curPos = idx + OFF;
    assign newPos = nextIdx + OFF;
    assign newMag = lutMag(newPos);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        decayQ <= DECAY_MIXED;
      else if (ctl.goHome)
        decayQ <= DECAY_MIXED;
      else if (ctl.advance)
        decayQ <= (newMag < mag[ph]) ? decay_e'(decaySel) : DECAY_SLOW;
    end

    assign mag[ph]   = lutMag(curPos);
    assign pol[ph]   = ~curPos[IDX_W-1];
    assign decay[ph] = decayQ;
  end
endmodule

// File: rtl/microstep_translator.sv
`timescale 1ns/1ps
module microstep_translator
  import mstep_pkg::*;
#(
  parameter int MAG_W         = 8,
  parameter int SETTLE_CYCLES = 50000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepIn,
  input  logic             dirIn,
  input  logic [1:0]       resSel,
  input  logic [1:0]       decaySel,
  input  logic             enN,
  input  logic             sleepN,
  output logic [MAG_W-1:0] magA,
  output logic             polA,
  output logic [MAG_W-1:0] magB,
  output logic             polB,
  output logic [1:0]       decayA,
  output logic [1:0]       decayB,
  output logic             homeOut,
  output logic             bridgeEn
);
  ctlStrobe_t       ctlBus;
  logic [IDX_W-1:0] idx;
  logic [MAG_W-1:0] mag [2];
  logic             pol [2];
  logic [1:0]       decay [2];

  mstep_control #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stepIn   (stepIn),
    .dirIn    (dirIn),
    .enN      (enN),
    .sleepN   (sleepN),
    .ctl      (ctlBus),
    .bridgeEn (bridgeEn)
  );

  mstep_datapath #(.MAG_W(MAG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctlBus),
    .resSel   (resSel),
    .decaySel (decaySel),
    .idx      (idx),
    .mag      (mag),
    .pol      (pol),
    .decay    (decay)
  );

  assign magA    = mag[0];
  assign polA    = pol[0];
  assign magB    = mag[1];
  assign polB    = pol[1];
  assign decayA  = decay[0];
  assign decayB  = decay[1];
  assign homeOut = (idx == IDX_W'(HOME_IDX));
endmodule

// File: rtl/mstep_checker.sv
`timescale 1ns/1ps
module mstep_checker #(
  parameter int MAG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enN,
  input logic             sleepN,
  input logic [4:0]       idx,
  input logic             advance,
  input logic [MAG_W-1:0] magA,
  input logic             polA,
  input logic [MAG_W-1:0] magB,
  input logic             polB,
  input logic [1:0]       decayA,
  input logic [1:0]       decayB,
  input logic             homeOut,
  input logic             bridgeEn
);
  always_comb begin
    if (rstN === 1'b0)
      AST_OFF_IN_RESET: assert (!bridgeEn); // R4
  end

  AST_BRIDGE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (enN || !sleepN) |-> !bridgeEn); // R8

  AST_LEGAL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (idx != $past(idx) && $past(sleepN)) |->
      (5'(idx - $past(idx)) inside {5'd1, 5'd2, 5'd4, 5'd8, 5'd24, 5'd28, 5'd30, 5'd31})); // R1

  AST_ASLEEP_HOME: assert property (@(posedge clk) disable iff (!rstN)
    !sleepN |=> (homeOut && decayA == 2'b10 && decayB == 2'b10)); // R9

  AST_SLOW_UNLESS_FALL_A: assert property (@(posedge clk) disable iff (!rstN)
    advance |=> (decayA == 2'b00 || magA < $past(magA))); // R6

  AST_SLOW_UNLESS_FALL_B: assert property (@(posedge clk) disable iff (!rstN)
    advance |=> (decayB == 2'b00 || magB < $past(magB))); // R6

  AST_WAKE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepN) |=> $stable(idx)); // R10

  AST_HOME_SYMMETRIC: assert property (@(posedge clk) disable iff (!rstN)
    homeOut |-> (magA == magB && polA && polB)); // R7
endmodule

bind microstep_translator mstep_checker #(.MAG_W(MAG_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enN      (enN),
  .sleepN   (sleepN),
  .idx      (idx),
  .advance  (ctlBus.advance),
  .magA     (magA),
  .polA     (polA),
  .magB     (magB),
  .polB     (polB),
  .decayA   (decayA),
  .decayB   (decayB),
  .homeOut  (homeOut),
  .bridgeEn (bridgeEn)
);

// File: tb/microstep_translator_tb.sv
`timescale 1ns/1ps
module microstep_translator_tb;
  localparam int MAG_W  = 8;
  localparam int SETTLE = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0, stepIn = 1'b0, dirIn = 1'b0, enN = 1'b0, sleepN = 1'b1;
  logic [1:0] resSel = 2'b00, decaySel = 2'b00;
  logic [MAG_W-1:0] magA, magB;
  logic polA, polB, homeOut, bridgeEn;
  logic [1:0] decayA, decayB;

  int nChecks = 0, nFails = 0;
  int cur = 4, expDA = 2, expDB = 2;
  bit finished = 1'b0;

  // {dir, res, decaySel, expected position}
  localparam logic [9:0] VEC [12] = '{
    {1'b1, 2'b00, 2'b01, 5'd12}, {1'b1, 2'b01, 2'b10, 5'd16},
    {1'b1, 2'b10, 2'b01, 5'd18}, {1'b1, 2'b11, 2'b01, 5'd19},
    {1'b0, 2'b11, 2'b10, 5'd18}, {1'b0, 2'b00, 2'b01, 5'd10},
    {1'b0, 2'b00, 2'b10, 5'd2},  {1'b0, 2'b00, 2'b01, 5'd26},
    {1'b1, 2'b01, 2'b10, 5'd30}, {1'b1, 2'b10, 2'b01, 5'd0},
    {1'b1, 2'b11, 2'b10, 5'd1},  {1'b0, 2'b10, 2'b01, 5'd31}
  };

  always #10 clk = ~clk;

  microstep_translator #(.MAG_W(MAG_W), .SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rstN(rstN), .stepIn(stepIn), .dirIn(dirIn), .resSel(resSel),
    .decaySel(decaySel), .enN(enN), .sleepN(sleepN), .magA(magA), .polA(polA),
    .magB(magB), .polB(polB), .decayA(decayA), .decayB(decayB),
    .homeOut(homeOut), .bridgeEn(bridgeEn)
  );

  function automatic int tblMag(int k);
    case (k)
      0: return 0;   1: return 49;  2: return 97;  3: return 142; 4: return 181;
      5: return 212; 6: return 236; 7: return 251; default: return 255;
    endcase
  endfunction
  function automatic int sinMag(int p);
    int q = p % 8;
    return (((p / 8) % 2) == 1) ? tblMag(8 - q) : tblMag(q);
  endfunction
  function automatic int expMagA(int p); return sinMag((p + 8) % 32); endfunction
  function automatic int expMagB(int p); return sinMag(p); endfunction
  function automatic int expPolA(int p); return (((p + 8) % 32) < 16) ? 1 : 0; endfunction
  function automatic int expPolB(int p); return (p < 16) ? 1 : 0; endfunction

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkPos(string req, int p);
    check(req, "magA", int'(magA), expMagA(p));
    check(req, "polA", int'(polA), expPolA(p));
    check(req, "magB", int'(magB), expMagB(p));
    check(req, "polB", int'(polB), expPolB(p));
    check(req, "decayA", int'(decayA), expDA);
    check(req, "decayB", int'(decayB), expDB);
    check("R7", "homeOut", int'(homeOut), (p == 4) ? 1 : 0);
  endtask

  // model of one accepted step: updates expected decays from magnitude change
  task automatic modelStep(int nxt, int dc);
    expDA = (expMagA(nxt) < expMagA(cur)) ? dc : 0;
    expDB = (expMagB(nxt) < expMagB(cur)) ? dc : 0;
    cur = nxt;
  endtask

  task automatic pulseStep(logic d, logic [1:0] r, logic [1:0] dc);
    @(negedge clk);
    dirIn = d; resSel = r; decaySel = dc; stepIn = 1'b1;
    repeat (4) @(negedge clk);
    stepIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R4", "bridgeEn in reset", int'(bridgeEn), 0);
    checkPos("R4", 4);
    rstN = 1'b1;
    @(negedge clk);
    check("R8", "bridgeEn enabled", int'(bridgeEn), 1);
    checkPos("R5", 4);

    // R2: latency of three edges
    @(negedge clk);
    dirIn = 1'b1; resSel = 2'b00; decaySel = 2'b01; stepIn = 1'b1;
    repeat (2) @(negedge clk);
    check("R2", "no move after two edges", int'(homeOut), 1);
    @(negedge clk);
    modelStep(12, 1);
    checkPos("R2", 12);
    stepIn = 1'b0;
    repeat (3) @(negedge clk);
    // R2: falling edge moves nothing
    checkPos("R2", 12);
    // walk back to home for the table
    pulseStep(1'b0, 2'b00, 2'b01);
    modelStep(4, 1);
    checkPos("R1", 4);

    for (int n = 0; n < 12; n++) begin
      logic [9:0] v;
      v = VEC[n];
      pulseStep(v[9], v[8:7], v[6:5]);
      modelStep(int'(v[4:0]), int'(v[6:5]));
      checkPos("R1 R5 R6", int'(v[4:0]));
    end

    // R3: resolution change without a step does nothing; next step uses it
    @(negedge clk); resSel = 2'b00;
    repeat (6) @(negedge clk);
    checkPos("R3", 31);
    pulseStep(1'b1, 2'b00, 2'b10);
    modelStep(7, 2);
    checkPos("R3", 7);

    // R8: disabled bridge, steps still processed
    enN = 1'b1;
    @(negedge clk);
    check("R8", "bridgeEn disabled", int'(bridgeEn), 0);
    pulseStep(1'b1, 2'b11, 2'b01);
    modelStep(8, 1);
    checkPos("R8", 8);
    enN = 1'b0;
    @(negedge clk);
    check("R8", "bridgeEn restored", int'(bridgeEn), 1);

    // R9: sleep forces home and mixed decay, ignores steps
    sleepN = 1'b0;
    repeat (2) @(negedge clk);
    cur = 4; expDA = 2; expDB = 2;
    check("R9", "bridgeEn asleep", int'(bridgeEn), 0);
    checkPos("R9", 4);
    pulseStep(1'b1, 2'b00, 2'b01);
    checkPos("R9", 4);

    // R10: step right after wake is dropped, later step accepted
    sleepN = 1'b1;
    pulseStep(1'b1, 2'b00, 2'b01);
    checkPos("R10", 4);
    repeat (SETTLE + 10) @(negedge clk);
    pulseStep(1'b1, 2'b11, 2'b01);
    modelStep(5, 1);
    checkPos("R10", 5);

    // R4: reset mid-run, steps ignored while held
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    cur = 4; expDA = 2; expDB = 2;
    check("R4", "bridgeEn in reset", int'(bridgeEn), 0);
    checkPos("R4", 4);
    pulseStep(1'b1, 2'b00, 2'b01);
    checkPos("R4", 4);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    checkPos("R4", 4);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule